// File: doc/BRIEF.md
# Packed Halfword Saturating Adder

This unit treats each of two 64-bit operands as four 16-bit lanes and adds or subtracts them lane by lane, with no carry or borrow crossing a lane boundary. Each lane result is either clamped to a signed range, clamped to an unsigned range, or allowed to wrap. The four lane results are packed back into a 64-bit word at the same positions the lanes came from.

The arithmetic is purely combinational. A parameter adds an output register with a load enable, so the unit can sit in a pipeline stage. An operation is chosen with a subtract flag and a two-bit mode code. In the unsigned-saturating mode, the first operand's lanes are read as unsigned values and the second operand's lanes as signed offsets. This lets a signed adjustment be applied to unsigned samples without leaving the 0..65535 range.

Top module: `hsat_pack_alu`

## Requirements
- R1: Lanes occupy bits [15:0], [31:16], [47:32] and [63:48] of each operand and of the result. Each result lane depends only on the same lane of the inputs; no carry or borrow passes between lanes.
- R2: With mode 2'b00 (signed saturate), both lanes are read as two's-complement values. The exact result is clamped to -32768..32767, so a positive overflow gives 16'h7FFF and a negative overflow gives 16'h8000.
- R3: With mode 2'b01 (mixed saturate), the first-operand lane is read as unsigned and the second-operand lane as signed. The exact result is clamped to 0..65535, so a negative result gives 16'h0000 and a result above 65535 gives 16'hFFFF.
- R4: With mode 2'b10 or 2'b11 (modulo), each lane returns the low 16 bits of the sum or difference, without clamping.
- R5: With op_sub = 1, each lane computes first operand minus second operand. The same mode rules apply; with op_sub = 0 it adds.
- R6: With the output register enabled (default), a cycle with load = 1 makes the result of that cycle's inputs appear after the next rising clock edge. A cycle with load = 0 leaves result unchanged whatever the inputs do.
- R7: While rst_n is low, result is 64'h0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Clock enable of the output register |
| op_a | input | 64 | First operand, four 16-bit lanes |
| op_b | input | 64 | Second operand, four 16-bit lanes (always signed) |
| op_sub | input | 1 | 1 = subtract (a - b), 0 = add |
| mode | input | 2 | 00 signed saturate, 01 mixed saturate, 1x modulo |
| result | output | 64 | Packed lane results |

## Verification
The assertions assume the output register is present and that the inputs are held steady around each rising edge, so the value sampled with load high is the one the lane arithmetic used. They also assume every mode code is legal, since both 1x codes are defined as modulo. The stimulus changes operands and controls only on falling edges and keeps rst_n low for whole cycles. The operand sets reach both clamp bounds in each saturating mode and mix different lane patterns in a single word, so that a carry leaking across a lane boundary would be visible.

// File: rtl/hsat_pkg.sv
package hsat_pkg;
  typedef enum logic [1:0] {
    SAT_SIGNED = 2'b00,
    SAT_MIXED  = 2'b01,
    WRAP_LO    = 2'b10,
    WRAP_HI    = 2'b11
  } sat_mode_e;
endpackage

// File: rtl/lane_addsub.sv
module lane_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0]        a,
  input  logic [W-1:0]        b,
  input  logic                sub,
  input  logic                a_unsigned,
  output logic signed [W+1:0] raw
);
  // two guard bits keep every sum/difference exact
  logic signed [W+1:0] ea, eb;

  always_comb begin
    ea  = a_unsigned ? {2'b00, a} : {{2{a[W-1]}}, a};
    eb  = {{2{b[W-1]}}, b};
    raw = sub ? (ea - eb) : (ea + eb);
  end
endmodule

// File: rtl/lane_clamp.sv
module lane_clamp
  import hsat_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W+1:0] raw,
  input  sat_mode_e           mode,
  output logic [W-1:0]        q
);
  localparam logic signed [W+1:0] S_MAX = $signed({3'b000, {(W-1){1'b1}}});
  localparam logic signed [W+1:0] S_MIN = $signed({3'b111, {(W-1){1'b0}}});
  localparam logic signed [W+1:0] U_MAX = $signed({2'b00, {W{1'b1}}});

  always_comb begin
    q = raw[W-1:0];
    case (mode)
      SAT_SIGNED: begin
        if (raw > S_MAX)      q = {1'b0, {(W-1){1'b1}}};
        else if (raw < S_MIN) q = {1'b1, {(W-1){1'b0}}};
      end
      SAT_MIXED: begin
        if (raw[W+1])         q = '0;
        else if (raw > U_MAX) q = '1;
      end
      default: q = raw[W-1:0];
    endcase
  end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int DW      = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  generate
    if (REG_OUT) begin : g_reg
      logic [DW-1:0] q_r, q_nxt;

      always_comb begin
        q_nxt = q_r;
        if (load) q_nxt = d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
      end

      assign q = q_r;
    end else begin : g_comb
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst_n, load};
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/hsat_pack_alu.sv
module hsat_pack_alu
  import hsat_pkg::*;
#(
  parameter int LANE_W  = 16,
  parameter int LANES   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [LANE_W*LANES-1:0]   op_a,
  input  logic [LANE_W*LANES-1:0]   op_b,
  input  logic                      op_sub,
  input  logic [1:0]                mode,
  output logic [LANE_W*LANES-1:0]   result
);
  localparam int DW = LANE_W * LANES;

  sat_mode_e   mode_e;
  logic        a_uns;
  logic [DW-1:0] packed_q;

  assign mode_e = sat_mode_e'(mode);
  assign a_uns  = (mode_e == SAT_MIXED);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic signed [LANE_W+1:0] raw;
      logic [LANE_W-1:0]        q;

      lane_addsub #(.W(LANE_W)) u_addsub (
        .a          (op_a[g*LANE_W +: LANE_W]),
        .b          (op_b[g*LANE_W +: LANE_W]),
        .sub        (op_sub),
        .a_unsigned (a_uns),
        .raw        (raw)
      );

      lane_clamp #(.W(LANE_W)) u_clamp (
        .raw  (raw),
        .mode (mode_e),
        .q    (q)
      );

      assign packed_q[g*LANE_W +: LANE_W] = q;
    end
  endgenerate

  out_stage #(.DW(DW), .REG_OUT(REG_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .d     (packed_q),
    .q     (result)
  );

  generate
    if (REG_OUT) begin : g_chk
      a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(result));

      for (genvar g = 0; g < LANES; g++) begin : g_lchk
        // R2 + R1: two non-negative signed lanes added never come out negative
        a_r2_no_pos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
          (load && mode == 2'b00 && !op_sub &&
           !op_a[g*LANE_W + LANE_W-1] && !op_b[g*LANE_W + LANE_W-1])
          |=> !result[g*LANE_W + LANE_W-1]);

        // R3: zero plus a negative offset floors at zero
        a_r3_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
          (load && mode == 2'b01 && !op_sub &&
           op_a[g*LANE_W +: LANE_W] == '0 && op_b[g*LANE_W + LANE_W-1])
          |=> result[g*LANE_W +: LANE_W] == '0);

        // R4 + R5: modulo lanes match truncated arithmetic
        a_r4_modulo: assert property (@(posedge clk) disable iff (!rst_n)
          (load && mode[1])
          |=> result[g*LANE_W +: LANE_W] ==
              $past(op_sub ? (op_a[g*LANE_W +: LANE_W] - op_b[g*LANE_W +: LANE_W])
                           : (op_a[g*LANE_W +: LANE_W] + op_b[g*LANE_W +: LANE_W])));
      end
    end
  endgenerate
endmodule

// File: tb/hsat_pack_alu_bench.sv
module hsat_pack_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load;
  logic [63:0] op_a, op_b;
  logic        op_sub;
  logic [1:0]  mode;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  hsat_pack_alu u_hsat_pack_alu (
    .clk(clk), .rst_n(rst_n), .load(load), .op_a(op_a), .op_b(op_b),
    .op_sub(op_sub), .mode(mode), .result(result)
  );

  function automatic logic [15:0] ref_lane(input logic [15:0] a, input logic [15:0] b,
                                           input logic s, input logic [1:0] m);
    int fa, fb, r;
    fa = (m == 2'b01) ? int'({16'h0, a}) : int'($signed(a));
    fb = int'($signed(b));
    r  = s ? fa - fb : fa + fb;
    if (m == 2'b00) begin
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
    end else if (m == 2'b01) begin
      if (r < 0) r = 0;
      if (r > 65535) r = 65535;
    end
    return r[15:0];
  endfunction

  function automatic logic [63:0] ref_word(input logic [63:0] a, input logic [63:0] b,
                                           input logic s, input logic [1:0] m);
    logic [63:0] w;
    for (int i = 0; i < 4; i++)
      w[i*16 +: 16] = ref_lane(a[i*16 +: 16], b[i*16 +: 16], s, m);
    return w;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [63:0] a, input logic [63:0] b,
                       input logic s, input logic [1:0] m);
    @(negedge clk);
    op_a = a; op_b = b; op_sub = s; mode = m; load = 1'b1;
    @(negedge clk);
    check(req, result, ref_word(a, b, s, m));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; load = 1'b0; op_a = '0; op_b = '0; op_sub = 1'b0; mode = 2'b00;
    repeat (2) @(negedge clk);
    check("R7", result, 64'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_signed_add();
    apply("R2", 64'h7FFF_8000_1234_0001, 64'h0001_FFFF_1111_7FFE, 1'b0, 2'b00);
    check("R2 bounds", result, 64'h7FFF_8000_2345_7FFF);
    apply("R2", 64'h4000_C000_7FFF_8000, 64'h4000_C000_7FFF_8000, 1'b0, 2'b00);
  endtask

  task automatic t_mixed();
    apply("R3", 64'hFFFF_0005_8000_0000, 64'h0001_FFF0_7FFF_8000, 1'b0, 2'b01);
    check("R3 bounds", result, 64'hFFFF_0000_FFFF_0000);
    apply("R3", 64'h0000_FFFF_1000_0010, 64'h0001_8000_F000_FFF0, 1'b1, 2'b01);
  endtask

  task automatic t_modulo();
    apply("R4", 64'h7FFF_FFFF_8000_1234, 64'h0001_0001_FFFF_4321, 1'b0, 2'b10);
    check("R4 wrap", result, 64'h8000_0000_7FFF_5555);
    apply("R4", 64'h0000_8000_1234_FFFF, 64'h0001_0001_0234_FFFF, 1'b1, 2'b11);
  endtask

  task automatic t_subtract();
    apply("R5", 64'h8000_7FFF_0003_0000, 64'h0001_FFFF_0005_8000, 1'b1, 2'b00);
    check("R5 bounds", result, 64'h8000_7FFF_FFFE_7FFF);
  endtask

  task automatic t_lanes();
    // R1: each lane overflows differently; no carry crosses a boundary
    apply("R1", 64'hFFFF_0000_FFFF_0000, 64'h0001_0000_0001_0000, 1'b0, 2'b10);
    check("R1 isolation", result, 64'h0000_0000_0000_0000);
    apply("R1", 64'h0001_FFFF_0001_FFFF, 64'h0000_0001_0000_0001, 1'b0, 2'b01);
  endtask

  task automatic t_sweep();
    logic [63:0] a, b;
    a = 64'h9E37_79B9_7F4A_7C15;
    b = 64'hC2B2_AE3D_27D4_EB4F;
    for (int k = 0; k < 24; k++) begin
      a = {a[62:0], a[63] ^ a[62] ^ a[60] ^ a[59]};
      b = b * 64'd6364136223846793005 + 64'd1442695040888963407;
      apply("R1 R2 R3 R4 R5 sweep", a, b, k[0], k[2:1]);
    end
  endtask

  task automatic t_hold();
    logic [63:0] held;
    apply("R6", 64'h1111_2222_3333_4444, 64'h0001_0002_0003_0004, 1'b0, 2'b00);
    held = result;
    @(negedge clk);
    load = 1'b0; op_a = 64'hFFFF_FFFF_FFFF_FFFF; op_b = 64'h7FFF_7FFF_7FFF_7FFF; mode = 2'b01;
    @(negedge clk);
    check("R6 hold", result, held);
    @(negedge clk);
    check("R6 hold", result, held);
    load = 1'b1;
    @(negedge clk);
    check("R6 load", result, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R7 async", result, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_signed_add();
    t_mixed();
    t_modulo();
    t_subtract();
    t_lanes();
    t_sweep();
    t_hold();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule